// File: doc/BRIEF.md
# Host Bridge Register and Window Decoder

This block is the register file that a processor uses to program a processor-to-PCI host bridge. It answers 32-bit reads and writes in a 4 KB space. Bits 11:2 of the byte address select one of 1024 word slots, and the upper bits are ignored. Only the slots the bridge defines hold state. Each of these applies its own write mask. A write to one of the six lower-bound decode registers also loads a narrower copy of the value into the matching remap register. Status slots for error capture, ECC and multi-bridge are read-only and always return their power-up contents. The two sync-barrier slots return a fixed token.

From the PCI0 I/O decode pair the block derives a live address window: a valid flag, a base and a size. Other logic uses this window to route processor accesses to PCI I/O space. When the decode pair is set to an empty range, the flag drops and the last valid base and size are kept. A build-time parameter selects big-endian hosts. With it set, write and read data cross a byte-lane swap, and the processor-configuration and command registers reset to zero.

Top module: `hb_ctrl_regs`

## Requirements
- R1: After reset, reads return these values. Byte offset 0x000 (CPU config) returns 0x800. The lower/upper decode pairs return PCI0 I/O 0x048/0x050 = 0x80/0x0F, PCI0 mem0 0x058/0x060 = 0x90/0x1F, PCI0 mem1 0x080/0x088 = 0x790/0x1F, PCI1 I/O 0x090/0x098 = 0x100/0x0F, PCI1 mem0 0x0A0/0x0A8 = 0x110/0x1F and PCI1 mem1 0x0B0/0x0B8 = 0x120/0x2F. The remaps at 0x0F0..0x118 (step 8, same order) equal the lower values. SDRAM bank parameters at 0x44C..0x458 return 5. Commands at 0xC00 and 0xC80 return 0x00010001. The config address at 0xCF8 returns 0.
- R2: Only address bits 11:2 select a register. An access at any address with the same bits 11:2 reaches the same register.
- R3: A write to a lower-decode register stores data & 0x7FFF. On the same clock edge it stores data & 0x7FF into that window's remap register.
- R4: A write to an upper-decode register stores data & 0x7F. A direct write to a remap register stores data & 0x7FF and leaves the lower register unchanged.
- R5: The command registers store data & 0x0401FC0F. The config-address register stores data & 0x80FFFFFC. The CPU config register and the SDRAM bank registers store all 32 bits.
- R6: Writes to these registers have no effect: multi-bridge (0x120), error address low/high (0x070, 0x078), error data low/high (0x128, 0x130), error parity (0x138) and ECC (0x480..0x490). They read 0, 0, 0xFFFFFFFF, 0xFF and 0 respectively.
- R7: A read of either sync-barrier register (0x0C0, 0x0C8) returns 0xC000FFEE.
- R8: The window is valid when (low & 0x7F) <= high. While valid, its base is low << 21 and its size is ((high + 1) - (low & 0x7F)) << 21, both truncated to 32 bits. While invalid, base and size keep their last valid values. The window outputs follow a decode change one clock after the register update. They reset to valid, base 0x10000000, size 0x02000000.
- R9: Writes to offsets not listed above store nothing, and reads of those offsets return 0.
- R10: rd_valid is high in the cycle after rd_en is sampled and low otherwise. A read and a write sampled on the same edge return the contents from before the write.
- R11: With BIG_ENDIAN = 1, write data and read data are byte-reversed, and the CPU config and command registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address; bits 11:2 select the register |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| win_valid | output | 1 | PCI0 I/O window is non-empty |
| win_start | output | 32 | PCI0 I/O window base address |
| win_len | output | 32 | PCI0 I/O window size in bytes |

## Verification
A read and a write can be sampled on the same edge. When both target a lower-decode register, the read path and two register updates act at once. The bench raises both strobes in one cycle on such a register. It expects the old value in the read response, then reads back the new lower value and its remap copy. It also checks that the window flag drops on an empty range while the base and size stay at their last valid values.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;

    localparam int WORD_W    = 32;
    localparam int IDX_W     = 10;
    localparam int N_WIN     = 6;
    localparam int N_CMD     = 2;
    localparam int N_SDP     = 4;
    localparam int LO_W      = 15;
    localparam int HI_W      = 7;
    localparam int RMP_W     = 11;
    localparam int WIN_SHIFT = 21;
    localparam int SPAN_W    = HI_W + 1;

    // word indices (byte offset >> 2)
    localparam logic [IDX_W-1:0] IX_CPU     = 10'h000;
    localparam logic [IDX_W-1:0] IX_MULTI   = 10'h048;
    localparam logic [IDX_W-1:0] IX_ERR_ALO = 10'h01C;
    localparam logic [IDX_W-1:0] IX_ERR_AHI = 10'h01E;
    localparam logic [IDX_W-1:0] IX_ERR_DLO = 10'h04A;
    localparam logic [IDX_W-1:0] IX_ERR_DHI = 10'h04C;
    localparam logic [IDX_W-1:0] IX_ERR_PAR = 10'h04E;
    localparam logic [IDX_W-1:0] IX_SYNC0   = 10'h030;
    localparam logic [IDX_W-1:0] IX_SYNC1   = 10'h032;
    localparam logic [IDX_W-1:0] IX_CFGA    = 10'h33E;

    localparam logic [IDX_W-1:0] IX_LO  [N_WIN] = '{10'h012, 10'h016, 10'h020, 10'h024, 10'h028, 10'h02C};
    localparam logic [IDX_W-1:0] IX_HI  [N_WIN] = '{10'h014, 10'h018, 10'h022, 10'h026, 10'h02A, 10'h02E};
    localparam logic [IDX_W-1:0] IX_RMP [N_WIN] = '{10'h03C, 10'h03E, 10'h040, 10'h042, 10'h044, 10'h046};
    localparam logic [IDX_W-1:0] IX_CMD [N_CMD] = '{10'h300, 10'h320};
    localparam logic [IDX_W-1:0] IX_SDP [N_SDP] = '{10'h113, 10'h114, 10'h115, 10'h116};

    localparam logic [LO_W-1:0] RST_LO [N_WIN] = '{15'h080, 15'h090, 15'h790, 15'h100, 15'h110, 15'h120};
    localparam logic [HI_W-1:0] RST_HI [N_WIN] = '{7'h0F, 7'h1F, 7'h1F, 7'h0F, 7'h1F, 7'h2F};

    localparam logic [WORD_W-1:0] MASK_CMD  = 32'h0401_FC0F;
    localparam logic [WORD_W-1:0] MASK_CFGA = 32'h80FF_FFFC;
    localparam logic [WORD_W-1:0] SYNC_WORD = 32'hC000_FFEE;
    localparam logic [WORD_W-1:0] ERR_PAR_V = 32'h0000_00FF;
    localparam logic [WORD_W-1:0] SDP_RST   = 32'h0000_0005;
    localparam logic [WORD_W-1:0] CPU_RST   = 32'h0000_0800;
    localparam logic [WORD_W-1:0] CMD_RST   = 32'h0001_0001;

    typedef struct packed {
        logic [WORD_W-1:0]             cpu;
        logic [N_WIN-1:0][LO_W-1:0]    lo;
        logic [N_WIN-1:0][HI_W-1:0]    hi;
        logic [N_WIN-1:0][RMP_W-1:0]   rmp;
        logic [N_CMD-1:0][WORD_W-1:0]  cmd;
        logic [WORD_W-1:0]             cfga;
        logic [N_SDP-1:0][WORD_W-1:0]  sdp;
        logic                          rd_vld;
        logic [WORD_W-1:0]             rd_word;
        logic                          win_ok;
        logic [WORD_W-1:0]             win_base;
        logic [WORD_W-1:0]             win_size;
    } hb_state_t;

    function automatic hb_state_t hb_reset_state(input logic big);
        hb_state_t s;
        logic [SPAN_W-1:0] span;
        s = '0;
        s.cpu = big ? '0 : CPU_RST;
        for (int k = 0; k < N_WIN; k++) begin
            s.lo[k]  = RST_LO[k];
            s.hi[k]  = RST_HI[k];
            s.rmp[k] = RST_LO[k][RMP_W-1:0];
        end
        for (int k = 0; k < N_CMD; k++) s.cmd[k] = big ? '0 : CMD_RST;
        for (int k = 0; k < N_SDP; k++) s.sdp[k] = SDP_RST;
        span       = {1'b0, RST_HI[0]} + SPAN_W'(1) - {1'b0, RST_LO[0][HI_W-1:0]};
        s.win_ok   = RST_LO[0][HI_W-1:0] <= RST_HI[0];
        s.win_base = {RST_LO[0][RMP_W-1:0], {WIN_SHIFT{1'b0}}};
        s.win_size = WORD_W'({span, {WIN_SHIFT{1'b0}}});
        return s;
    endfunction

endpackage

// File: rtl/hb_lane_swap.sv
module hb_lane_swap #(
    parameter int  W      = 32,
    parameter bit  ENABLE = 1'b0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    generate
        if (ENABLE) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_lane
                assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/hb_window_calc.sv
module hb_window_calc
    import hb_ctrl_pkg::*;
(
    input  logic [RMP_W-1:0]  lo,
    input  logic [HI_W-1:0]   hi,
    output logic              ok,
    output logic [WORD_W-1:0] base,
    output logic [WORD_W-1:0] size
);
    logic [SPAN_W-1:0] span;

    always_comb begin
        ok   = lo[HI_W-1:0] <= hi;
        span = {1'b0, hi} + SPAN_W'(1) - {1'b0, lo[HI_W-1:0]};
        base = {lo, {WIN_SHIFT{1'b0}}};
        size = WORD_W'({span, {WIN_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/hb_ctrl_regs.sv
module hb_ctrl_regs
    import hb_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              win_valid,
    output logic [31:0]       win_start,
    output logic [31:0]       win_len
);
    hb_state_t         s_q, s_d;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_raw;
    logic              calc_ok;
    logic [WORD_W-1:0] calc_base, calc_size;
    logic              unused_addr;

    assign idx         = addr[IDX_W+1:2];
    assign unused_addr = ^{addr[ADDR_W-1:IDX_W+2], addr[1:0]};

    hb_lane_swap #(.W(WORD_W), .ENABLE(BIG_ENDIAN)) u_swap_in (
        .din  (wr_data),
        .dout (wr_word)
    );

    hb_lane_swap #(.W(WORD_W), .ENABLE(BIG_ENDIAN)) u_swap_out (
        .din  (s_q.rd_word),
        .dout (rd_data)
    );

    hb_window_calc u_win (
        .lo   (s_q.lo[0][RMP_W-1:0]),
        .hi   (s_q.hi[0]),
        .ok   (calc_ok),
        .base (calc_base),
        .size (calc_size)
    );

    always_comb begin
        s_d    = s_q;
        rd_raw = '0;

        // read mux over pre-write contents
        if (idx == IX_CPU)                            rd_raw = s_q.cpu;
        if (idx == IX_ERR_DLO || idx == IX_ERR_DHI)   rd_raw = '1;
        if (idx == IX_ERR_PAR)                        rd_raw = ERR_PAR_V;
        if (idx == IX_SYNC0 || idx == IX_SYNC1)       rd_raw = SYNC_WORD;
        if (idx == IX_CFGA)                           rd_raw = s_q.cfga;
        for (int k = 0; k < N_WIN; k++) begin
            if (idx == IX_LO[k])  rd_raw = WORD_W'(s_q.lo[k]);
            if (idx == IX_HI[k])  rd_raw = WORD_W'(s_q.hi[k]);
            if (idx == IX_RMP[k]) rd_raw = WORD_W'(s_q.rmp[k]);
        end
        for (int k = 0; k < N_CMD; k++)
            if (idx == IX_CMD[k]) rd_raw = s_q.cmd[k];
        for (int k = 0; k < N_SDP; k++)
            if (idx == IX_SDP[k]) rd_raw = s_q.sdp[k];

        s_d.rd_vld = rd_en;
        if (rd_en) s_d.rd_word = rd_raw;

        // masked writes; read-only and unlisted slots fall through
        if (wr_en) begin
            if (idx == IX_CPU)  s_d.cpu  = wr_word;
            if (idx == IX_CFGA) s_d.cfga = wr_word & MASK_CFGA;
            for (int k = 0; k < N_WIN; k++) begin
                if (idx == IX_LO[k]) begin
                    s_d.lo[k]  = wr_word[LO_W-1:0];
                    s_d.rmp[k] = wr_word[RMP_W-1:0];
                end
                if (idx == IX_HI[k])  s_d.hi[k]  = wr_word[HI_W-1:0];
                if (idx == IX_RMP[k]) s_d.rmp[k] = wr_word[RMP_W-1:0];
            end
            for (int k = 0; k < N_CMD; k++)
                if (idx == IX_CMD[k]) s_d.cmd[k] = wr_word & MASK_CMD;
            for (int k = 0; k < N_SDP; k++)
                if (idx == IX_SDP[k]) s_d.sdp[k] = wr_word;
        end

        // window follows the registered decode pair, holds when empty
        s_d.win_ok = calc_ok;
        if (calc_ok) begin
            s_d.win_base = calc_base;
            s_d.win_size = calc_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= hb_reset_state(BIG_ENDIAN);
        else        s_q <= s_d;
    end

    assign rd_valid  = s_q.rd_vld;
    assign win_valid = s_q.win_ok;
    assign win_start = s_q.win_base;
    assign win_len   = s_q.win_size;

endmodule

module hb_ctrl_regs_chk
    import hb_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              win_valid,
    input logic [31:0]       win_start,
    input logic [31:0]       win_len
);
    localparam logic [31:0] EXP_SYNC = BIG_ENDIAN ? {SYNC_WORD[7:0], SYNC_WORD[15:8], SYNC_WORD[23:16], SYNC_WORD[31:24]} : SYNC_WORD;
    localparam logic [31:0] EXP_PAR  = BIG_ENDIAN ? {ERR_PAR_V[7:0], 24'h0} : ERR_PAR_V;
    localparam logic [IDX_W-1:0] IX_FREE = 10'h3FF;

    logic [IDX_W-1:0] cidx;
    logic             unused_caddr;
    assign cidx         = addr[IDX_W+1:2];
    assign unused_caddr = ^{addr[ADDR_W-1:IDX_W+2], addr[1:0]};

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);                                        // R10
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);                                      // R10
    AST_SYNC_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (cidx == IX_SYNC0 || cidx == IX_SYNC1)) |=> rd_data == EXP_SYNC); // R7
    AST_PARITY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cidx == IX_ERR_PAR) |=> rd_data == EXP_PAR);      // R6
    AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cidx == IX_FREE) |=> rd_data == 32'h0);           // R9
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> ($stable(win_start) && $stable(win_len)));   // R8
    AST_WIN_SIZE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_len != 32'h0 && win_len[20:0] == 21'h0)); // R8
endmodule

bind hb_ctrl_regs hb_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .win_valid (win_valid),
    .win_start (win_start),
    .win_len   (win_len)
);

// File: tb/tb_hb_ctrl_regs.sv
`timescale 1ns/1ps
module tb_hb_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        le_wr = 1'b0, le_rd = 1'b0, be_wr = 1'b0, be_rd = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic        le_rdv, be_rdv, le_wv, be_wv;
    logic [31:0] le_rdd, be_rdd, le_ws, le_wl, be_ws, be_wl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hb_ctrl_regs #(.BIG_ENDIAN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(le_wr), .rd_en(le_rd), .addr(addr),
        .wr_data(wdata), .rd_valid(le_rdv), .rd_data(le_rdd),
        .win_valid(le_wv), .win_start(le_ws), .win_len(le_wl)
    );

    hb_ctrl_regs #(.BIG_ENDIAN(1'b1)) dut_be (
        .clk(clk), .rst_n(rst_n), .wr_en(be_wr), .rd_en(be_rd), .addr(addr),
        .wr_data(wdata), .rd_valid(be_rdv), .rd_data(be_rdd),
        .win_valid(be_wv), .win_start(be_ws), .win_len(be_wl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit be, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (be) be_wr = 1'b1; else le_wr = 1'b1;
        @(negedge clk);
        le_wr = 1'b0; be_wr = 1'b0;
    endtask

    task automatic rd(input bit be, input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        if (be) be_rd = 1'b1; else le_rd = 1'b1;
        @(negedge clk);
        le_rd = 1'b0; be_rd = 1'b0;
        check({tag, " valid"}, 32'(be ? be_rdv : le_rdv), 32'h1);
        check(tag, be ? be_rdd : le_rdd, exp);
    endtask

    task automatic win_chk(input logic v, input logic [31:0] s, input logic [31:0] l, input string tag);
        @(negedge clk);
        check({tag, " valid"}, 32'(le_wv), 32'(v));
        check({tag, " start"}, le_ws, s);
        check({tag, " len"},   le_wl, l);
    endtask

    task automatic t_reset();
        win_chk(1'b1, 32'h1000_0000, 32'h0200_0000, "R8 reset window");
        rd(0, 32'h000, 32'h0000_0800, "R1 cpu");
        rd(0, 32'h048, 32'h80,        "R1 pci0 io low");
        rd(0, 32'h050, 32'h0F,        "R1 pci0 io high");
        rd(0, 32'h080, 32'h790,       "R1 pci0 mem1 low");
        rd(0, 32'h0B8, 32'h2F,        "R1 pci1 mem1 high");
        rd(0, 32'h118, 32'h120,       "R1 pci1 mem1 remap");
        rd(0, 32'h44C, 32'h5,         "R1 sdram bank0");
        rd(0, 32'hC00, 32'h0001_0001, "R1 pci0 command");
        rd(0, 32'hCF8, 32'h0,         "R1 config address");
    endtask

    task automatic t_low_remap();
        wr(0, 32'h0B0, 32'hFFFF_FFFF);
        rd(0, 32'h0B0, 32'h7FFF, "R3 low mask");
        rd(0, 32'h118, 32'h7FF,  "R3 remap copy");
        wr(0, 32'h058, 32'h0001_2345);
        rd(0, 32'h058, 32'h2345, "R3 low value");
        rd(0, 32'h0F8, 32'h345,  "R3 remap value");
    endtask

    task automatic t_masks();
        wr(0, 32'h0A8, 32'hFFFF_FFFF);
        rd(0, 32'h0A8, 32'h7F,   "R4 high mask");
        wr(0, 32'h0F8, 32'hFFFF_FFFF);
        rd(0, 32'h0F8, 32'h7FF,  "R4 remap direct");
        rd(0, 32'h058, 32'h2345, "R4 low untouched");
        wr(0, 32'hC80, 32'hFFFF_FFFF);
        rd(0, 32'hC80, 32'h0401_FC0F, "R5 command mask");
        wr(0, 32'hCF8, 32'hFFFF_FFFF);
        rd(0, 32'hCF8, 32'h80FF_FFFC, "R5 config address mask");
        wr(0, 32'h000, 32'hDEAD_BEEF);
        rd(0, 32'h000, 32'hDEAD_BEEF, "R5 cpu full");
        wr(0, 32'h458, 32'hA5A5_A5A5);
        rd(0, 32'h458, 32'hA5A5_A5A5, "R5 sdram full");
    endtask

    task automatic t_readonly();
        wr(0, 32'h120, 32'hFFFF_FFFF);
        rd(0, 32'h120, 32'h0,        "R6 multi");
        wr(0, 32'h130, 32'h0);
        rd(0, 32'h130, 32'hFFFF_FFFF, "R6 error data high");
        wr(0, 32'h138, 32'h0);
        rd(0, 32'h138, 32'hFF,       "R6 error parity");
        wr(0, 32'h48C, 32'hFFFF_FFFF);
        rd(0, 32'h48C, 32'h0,        "R6 ecc");
        wr(0, 32'h070, 32'h1234_5678);
        rd(0, 32'h070, 32'h0,        "R6 error address low");
    endtask

    task automatic t_sync();
        wr(0, 32'h0C0, 32'h0);
        rd(0, 32'h0C0, 32'hC000_FFEE, "R7 sync0");
        rd(0, 32'h0C8, 32'hC000_FFEE, "R7 sync1");
    endtask

    task automatic t_unlisted();
        wr(0, 32'h3FC, 32'hFFFF_FFFF);
        rd(0, 32'h3FC, 32'h0, "R9 unlisted 0x3FC");
        wr(0, 32'hFFC, 32'h5555_5555);
        rd(0, 32'hFFC, 32'h0, "R9 unlisted 0xFFC");
        wr(0, 32'h468, 32'h1);
        rd(0, 32'h468, 32'h0, "R9 unlisted 0x468");
    endtask

    task automatic t_alias();
        wr(0, 32'hABCD_E0A8, 32'h33);
        rd(0, 32'h0A8, 32'h33,           "R2 alias write");
        rd(0, 32'h5555_50A8, 32'h33,     "R2 alias read");
    endtask

    task automatic t_window();
        wr(0, 32'h050, 32'h20);
        wr(0, 32'h048, 32'h05);
        win_chk(1'b1, 32'h00A0_0000, 32'h0380_0000, "R8 normal");
        wr(0, 32'h048, 32'h7FFF);
        win_chk(1'b0, 32'h00A0_0000, 32'h0380_0000, "R8 empty holds");
        wr(0, 32'h048, 32'h20);
        win_chk(1'b1, 32'h0400_0000, 32'h0020_0000, "R8 equal bounds");
        wr(0, 32'h048, 32'h185);
        win_chk(1'b1, 32'h30A0_0000, 32'h0380_0000, "R8 upper low bits");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        addr = 32'h0A0; wdata = 32'h1ABC; le_wr = 1'b1; le_rd = 1'b1;
        @(negedge clk);
        le_wr = 1'b0; le_rd = 1'b0;
        check("R10 same-cycle read old", le_rdd, 32'h110);
        @(negedge clk);
        check("R10 idle valid low", 32'(le_rdv), 32'h0);
        rd(0, 32'h0A0, 32'h1ABC, "R10 new low");
        rd(0, 32'h110, 32'h2BC,  "R10 new remap");
    endtask

    task automatic t_big_endian();
        rd(1, 32'h000, 32'h0,         "R11 cpu reset");
        rd(1, 32'hC00, 32'h0,         "R11 command reset");
        rd(1, 32'h048, 32'h8000_0000, "R11 low swapped");
        rd(1, 32'h0C0, 32'hEEFF_00C0, "R11 sync swapped");
        wr(1, 32'h050, 32'h0000_007F);
        rd(1, 32'h050, 32'h0,         "R11 write swapped off mask");
        wr(1, 32'h050, 32'h0500_0000);
        rd(1, 32'h050, 32'h0500_0000, "R11 write swapped in mask");
        @(negedge clk);
        check("R11 window start", be_ws, 32'h1000_0000);
        check("R11 window len",   be_wl, 32'h00C0_0000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_low_remap();
        t_masks();
        t_readonly();
        t_sync();
        t_unlisted();
        t_alias();
        t_window();
        t_same_cycle();
        t_big_endian();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule